// File: doc/BRIEF.md
# Disk Controller Port Window Decoder

This block sits on an 8-bit processor I/O bus and turns port accesses into chip selects for a floppy disk controller board. The board occupies a window of sixteen ports, `E0h` to `EFh`. The lower four ports go to a parallel I/O device and the next four go to the disk controller chip. One write-only port fires a self-timed master reset into the controller so that software can recover a hung chip. Another write-only port holds the drive, side and density selection. The remaining ports in the window are unused.

The port selects, the register-select lines and the bus-drive enable are combinational from the address and the active-low strobes, so the attached devices see them within the same bus cycle. The reset pulse and the drive latch run on the system clock. They are triggered by the qualified write strobe after it has passed through a synchroniser and an edge detector. The address and write data must therefore stay stable until the third clock edge after the write strobe goes active.

Top module: `fdc_port_decoder`

## Requirements
- R1: Only address bits 7..0 are decoded. Address bits 15..8 have no effect on any output or on which port a write reaches.
- R2: `grp_sel` is high exactly when address bits 7..4 equal `Eh`, whatever the strobes. `nib_f` is high exactly when `grp_sel` is high and address bits 3..0 equal `Fh`.
- R3: A read cycle needs `rd_n` and `iocyc_n` both low. A write cycle needs `wr_n` and `iocyc_n` both low. Without a read or write cycle, no device select and no bus drive is active.
- R4: `pio_sel` is high during a read or write cycle to ports `E0h`–`E3h` and at no other time. `reg_sel` always equals address bits 1..0.
- R5: `fdc_sel` is high during a read or write cycle to ports `E4h`–`E7h` and at no other time. Ports `E9h`–`EEh` assert neither select.
- R6: `bus_drive` is high only during a read cycle, with `wr_n` high, to a port in `E0h`–`E7h`. Reads of `E8h`–`EFh` never drive the bus.
- R7: A write cycle to port `E8h` drives `fdc_mr_n` low from the third rising clock edge after the strobes go active, for exactly `RST_LEN` clock cycles.
- R8: A new write to `E8h` while the pulse is running restarts the count, so the pulse lasts `RST_LEN` cycles from the last load.
- R9: A write cycle to port `EFh` loads the drive latch on that same third edge. `drive_sel[3:0]` takes data bits 3..0, where bit 0 is the internal drive and bits 1–3 are the external drives. `side_sel` takes data bit 4 and `dens_sel` takes data bit 5. Data bits 7..6 are ignored.
- R10: If data bits 3..0 written to `EFh` have more than one bit set, `drive_sel` loads as zero, while `side_sel` and `dens_sel` still load.
- R11: The latch and the reset pulse are left unchanged by the following accesses:
  - writes to any port other than `E8h` or `EFh`;
  - reads of any port;
  - strobes without `iocyc_n` low.
- R12: While `rst` is high at a clock edge, the latch clears to zero and `fdc_mr_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus address; only bits 7..0 are decoded |
| wdata | input | 8 | Bus write data |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| iocyc_n | input | 1 | Active-low I/O cycle strobe |
| grp_sel | output | 1 | Window group select (address nibble `Eh`) |
| nib_f | output | 1 | Low nibble `Fh` detected inside the window |
| pio_sel | output | 1 | Parallel I/O device select |
| fdc_sel | output | 1 | Disk controller chip select |
| reg_sel | output | 2 | Register select lines for both devices |
| bus_drive | output | 1 | Enable for driving read data onto the bus |
| fdc_mr_n | output | 1 | Active-low master reset pulse to the controller |
| drive_sel | output | 4 | One-hot drive selects (bit 0 internal, bits 1–3 external) |
| side_sel | output | 1 | Head side select |
| dens_sel | output | 1 | Density / mode select |

## Verification
The combinational decode is swept over all 256 low address bytes, with three different upper bytes and all eight combinations of the three strobes. This separates the address terms from the strobe qualification, and it shows that the upper byte has no effect. The reset pulse is measured on its own to find its first low cycle and its length, and again with a second write issued in the middle of the pulse to show that the count restarts. The drive latch is written with one-hot values, a zero value and a value with several bits set. It is then bombarded with writes to every other window port, reads, and strobes without the I/O cycle strobe, and it must hold its contents through all of them.

// File: rtl/fdc_dec_pkg.sv
package fdc_dec_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int DRV_W   = 4;
  localparam logic [3:0] WIN_HI   = 4'hE;
  localparam logic [3:0] RST_PORT = 4'h8;
  localparam logic [3:0] LAT_PORT = 4'hF;
  localparam int SIDE_BIT = DRV_W;
  localparam int DENS_BIT = DRV_W + 1;

  typedef struct packed {
    logic             dens;
    logic             side;
    logic [DRV_W-1:0] drv;
  } drv_latch_t;
endpackage

// File: rtl/fdc_strobe_sync.sv
module fdc_strobe_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] prev;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-2:0], din[g]};
    end
    assign dout[g] = sh[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= dout;
  end

  assign rise = dout & ~prev;
endmodule

// File: rtl/fdc_addr_decode.sv
module fdc_addr_decode
  import fdc_dec_pkg::*;
(
  input  logic [7:0] addr_lo,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       iocyc_n,
  output logic       grp_sel,
  output logic       nib_f,
  output logic       pio_sel,
  output logic       fdc_sel,
  output logic [1:0] reg_sel,
  output logic       bus_drive,
  output logic       hit_rst
);
  logic       rd_cyc, wr_cyc, acc;
  logic [3:0] lo;

  always_comb begin
    rd_cyc    = !rd_n && !iocyc_n;
    wr_cyc    = !wr_n && !iocyc_n;
    acc       = rd_cyc || wr_cyc;
    lo        = addr_lo[3:0];
    grp_sel   = (addr_lo[7:4] == WIN_HI);
    nib_f     = grp_sel && (lo == LAT_PORT);
    hit_rst   = grp_sel && (lo == RST_PORT);
    pio_sel   = grp_sel && acc && (lo[3:2] == 2'b00);
    fdc_sel   = grp_sel && acc && (lo[3:2] == 2'b01);
    reg_sel   = addr_lo[1:0];
    bus_drive = grp_sel && rd_cyc && !wr_cyc && !lo[3];
  end
endmodule

// File: rtl/fdc_reset_pulse.sv
module fdc_reset_pulse #(
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic mr_n
);
  localparam int CNT_W = $clog2(RST_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_LEN);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      mr_n <= 1'b1;
    end else begin
      if (start)         cnt <= LOAD;
      else if (cnt != 0) cnt <= cnt - 1'b1;
      mr_n <= !(start || (cnt > 1));
    end
  end
endmodule

// File: rtl/fdc_drive_latch.sv
module fdc_drive_latch
  import fdc_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DENS_BIT:0] din,
  output drv_latch_t        q
);
  logic [DRV_W-1:0] drv_in;
  logic             single;

  always_comb begin
    drv_in = din[DRV_W-1:0];
    single = ((drv_in & (drv_in - 1'b1)) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q.drv  <= single ? drv_in : '0;
      q.side <= din[SIDE_BIT];
      q.dens <= din[DENS_BIT];
    end
  end
endmodule

// File: rtl/fdc_port_decoder.sv
module fdc_port_decoder
  import fdc_dec_pkg::*;
#(
  parameter int RST_LEN     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              iocyc_n,
  output logic              grp_sel,
  output logic              nib_f,
  output logic              pio_sel,
  output logic              fdc_sel,
  output logic [1:0]        reg_sel,
  output logic              bus_drive,
  output logic              fdc_mr_n,
  output logic [DRV_W-1:0]  drive_sel,
  output logic              side_sel,
  output logic              dens_sel
);
  logic       hit_rst;
  logic [0:0] wr_raw, wr_sync, wr_rise;
  logic       pulse_start, latch_ld;
  drv_latch_t lat_q;
  logic       unused_bits;

  assign unused_bits = ^{addr[ADDR_W-1:8], wdata[DATA_W-1:DENS_BIT+1]};

  fdc_addr_decode u_dec (
    .addr_lo  (addr[7:0]),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .iocyc_n  (iocyc_n),
    .grp_sel  (grp_sel),
    .nib_f    (nib_f),
    .pio_sel  (pio_sel),
    .fdc_sel  (fdc_sel),
    .reg_sel  (reg_sel),
    .bus_drive(bus_drive),
    .hit_rst  (hit_rst)
  );

  assign wr_raw = !wr_n && !iocyc_n;

  fdc_strobe_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (wr_raw),
    .dout(wr_sync),
    .rise(wr_rise)
  );

  assign pulse_start = wr_rise[0] && hit_rst;
  assign latch_ld    = wr_rise[0] && nib_f;

  fdc_reset_pulse #(.RST_LEN(RST_LEN)) u_pulse (
    .clk  (clk),
    .rst  (rst),
    .start(pulse_start),
    .mr_n (fdc_mr_n)
  );

  fdc_drive_latch u_latch (
    .clk (clk),
    .rst (rst),
    .load(latch_ld),
    .din (wdata[DENS_BIT:0]),
    .q   (lat_q)
  );

  assign drive_sel = lat_q.drv;
  assign side_sel  = lat_q.side;
  assign dens_sel  = lat_q.dens;
endmodule

// File: rtl/fdc_port_decoder_chk.sv
module fdc_port_decoder_chk #(
  parameter int RST_LEN = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       rd_n,
  input logic       wr_n,
  input logic       iocyc_n,
  input logic [7:0] wdata,
  input logic       grp_sel,
  input logic       nib_f,
  input logic       pio_sel,
  input logic       fdc_sel,
  input logic       bus_drive,
  input logic       fdc_mr_n,
  input logic [3:0] drive_sel,
  input logic       side_sel,
  input logic       dens_sel,
  input logic       pulse_start,
  input logic       latch_ld
);
  localparam int LW = $clog2(RST_LEN + 1) + 1;
  logic [LW-1:0] lowcnt;

  always_ff @(posedge clk) begin
    if (rst)                                         lowcnt <= '0;
    else if (pulse_start)                            lowcnt <= 1;
    else if (lowcnt != 0 && lowcnt < LW'(RST_LEN))   lowcnt <= lowcnt + 1'b1;
    else                                             lowcnt <= '0;
  end

  AST_NIBF_IN_GRP: assert property (@(posedge clk) disable iff (rst)
    nib_f |-> grp_sel); // R2
  AST_SEL_QUAL: assert property (@(posedge clk) disable iff (rst)
    (pio_sel || fdc_sel) |-> (!iocyc_n && (!rd_n || !wr_n))); // R3
  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pio_sel && fdc_sel)); // R4
  AST_DRIVE_READ: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> (!rd_n && wr_n && !iocyc_n && (pio_sel || fdc_sel))); // R6
  AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
    pulse_start |=> !fdc_mr_n); // R7
  AST_PULSE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    fdc_mr_n == (lowcnt == 0)); // R8
  AST_LATCH_SIDE: assert property (@(posedge clk) disable iff (rst)
    latch_ld |=> (side_sel == $past(wdata[4]) && dens_sel == $past(wdata[5]))); // R9
  AST_DRV_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drive_sel)); // R10
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !latch_ld |=> $stable({dens_sel, side_sel, drive_sel})); // R11
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (fdc_mr_n && drive_sel == 4'd0 && !side_sel && !dens_sel)); // R12
endmodule

bind fdc_port_decoder fdc_port_decoder_chk #(.RST_LEN(RST_LEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .iocyc_n    (iocyc_n),
  .wdata      (wdata),
  .grp_sel    (grp_sel),
  .nib_f      (nib_f),
  .pio_sel    (pio_sel),
  .fdc_sel    (fdc_sel),
  .bus_drive  (bus_drive),
  .fdc_mr_n   (fdc_mr_n),
  .drive_sel  (drive_sel),
  .side_sel   (side_sel),
  .dens_sel   (dens_sel),
  .pulse_start(pulse_start),
  .latch_ld   (latch_ld)
);

// File: tb/fdc_port_decoder_bench.sv
module fdc_port_decoder_bench;
  localparam int RL = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd_n = 1'b1, wr_n = 1'b1, iocyc_n = 1'b1;
  logic        grp_sel, nib_f, pio_sel, fdc_sel, bus_drive, fdc_mr_n;
  logic        side_sel, dens_sel;
  logic [1:0]  reg_sel;
  logic [3:0]  drive_sel;

  int n_chk = 0, n_fail = 0;
  int run = 0, last_run = 0, npulse = 0;
  bit done = 0;

  fdc_port_decoder #(.RST_LEN(RL)) u_fdc_port_decoder (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .rd_n(rd_n), .wr_n(wr_n), .iocyc_n(iocyc_n),
    .grp_sel(grp_sel), .nib_f(nib_f), .pio_sel(pio_sel), .fdc_sel(fdc_sel),
    .reg_sel(reg_sel), .bus_drive(bus_drive), .fdc_mr_n(fdc_mr_n),
    .drive_sel(drive_sel), .side_sel(side_sel), .dens_sel(dens_sel)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst) run = 0;
    else if (!fdc_mr_n) run = run + 1;
    else if (run != 0) begin
      last_run = run; npulse = npulse + 1; run = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic [7:0] d,
                        input bit rd, input bit wr, input bit io);
    @(negedge clk);
    addr = a; wdata = d; rd_n = !rd; wr_n = !wr; iocyc_n = !io;
    repeat (3) @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1; iocyc_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [5:0] lat_exp(input logic [7:0] d);
    logic [3:0] dv;
    dv = d[3:0];
    if ((dv & (dv - 4'd1)) != 4'd0) dv = 4'd0;
    return {d[5], d[4], dv};
  endfunction

  task automatic chk_latch(input logic [5:0] e, input string tag);
    chk({dens_sel, side_sel, drive_sel} == e, tag,
        {dens_sel, side_sel, drive_sel}, e);
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [5:0] held;
    int np0;
    do_reset();
    // R12: state after reset
    chk(fdc_mr_n == 1'b1, "R12 mr_n", fdc_mr_n, 1);
    chk_latch(6'd0, "R12 latch");

    // R1..R6: exhaustive decode sweep
    for (int u = 0; u < 3; u++) begin
      for (int a = 0; a < 256; a++) begin
        for (int s = 0; s < 8; s++) begin
          logic [7:0] hi;
          bit rc, wc, g;
          int lo;
          hi = (u == 0) ? 8'h00 : (u == 1) ? 8'hA5 : 8'hFF;
          @(negedge clk);
          addr = {hi, 8'(a)};
          {rd_n, wr_n, iocyc_n} = 3'(s);
          #1;
          rc = !rd_n && !iocyc_n;
          wc = !wr_n && !iocyc_n;
          g  = (a / 16) == 14;
          lo = a % 16;
          chk(grp_sel == g, "R2 R1 grp_sel", grp_sel, g);
          chk(nib_f == (g && lo == 15), "R2 nib_f", nib_f, g && lo == 15);
          chk(pio_sel == (g && lo < 4 && (rc || wc)), "R4 R3 pio_sel", pio_sel,
              g && lo < 4 && (rc || wc));
          chk(fdc_sel == (g && lo >= 4 && lo < 8 && (rc || wc)), "R5 R3 fdc_sel",
              fdc_sel, g && lo >= 4 && lo < 8 && (rc || wc));
          chk(reg_sel == 2'(a % 4), "R4 reg_sel", reg_sel, a % 4);
          chk(bus_drive == (g && lo < 8 && rc && !wc), "R6 bus_drive", bus_drive,
              g && lo < 8 && rc && !wc);
        end
      end
    end
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1; iocyc_n = 1'b1;
    do_reset();
    chk_latch(6'd0, "R12 latch after reset");
    chk(fdc_mr_n == 1'b1, "R12 mr_n after reset", fdc_mr_n, 1);
    repeat (RL + 4) @(negedge clk);
    npulse = 0; last_run = 0;

    // R7: pulse start and length
    addr = 16'h00E8; wr_n = 1'b0; iocyc_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(fdc_mr_n == 1'b1, "R7 before third edge", fdc_mr_n, 1);
    @(negedge clk);
    chk(fdc_mr_n == 1'b0, "R7 at third edge", fdc_mr_n, 0);
    wr_n = 1'b1; iocyc_n = 1'b1;
    repeat (RL + 4) @(negedge clk);
    chk(last_run == RL, "R7 pulse length", last_run, RL);
    chk(npulse == 1, "R7 pulse count", npulse, 1);

    // R8: restart during pulse
    addr = 16'h77E8; wr_n = 1'b0; iocyc_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1; iocyc_n = 1'b1;
    repeat (2) @(negedge clk);
    wr_n = 1'b0; iocyc_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1; iocyc_n = 1'b1;
    repeat (RL + 6) @(negedge clk);
    chk(last_run == RL + 5, "R8 restarted length", last_run, RL + 5);
    chk(npulse == 2, "R8 single pulse", npulse, 2);

    // R9, R10: latch loads
    access(16'h00EF, 8'h01, 0, 1, 1); chk_latch(lat_exp(8'h01), "R9 internal drive");
    access(16'h00EF, 8'hF4, 0, 1, 1); chk_latch(lat_exp(8'hF4), "R9 side dens upper ignored");
    access(16'h00EF, 8'h18, 0, 1, 1); chk_latch(lat_exp(8'h18), "R9 drive3 side");
    access(16'h3CEF, 8'h02, 0, 1, 1); chk_latch(lat_exp(8'h02), "R9 R1 upper byte");
    access(16'h00EF, 8'h23, 0, 1, 1); chk_latch(6'h20, "R10 multi-bit drive");
    access(16'h00EF, 8'h3F, 0, 1, 1); chk_latch(6'h30, "R10 all drives");
    access(16'h00EF, 8'h00, 0, 1, 1); chk_latch(6'h00, "R9 zero");
    access(16'h00EF, 8'h12, 0, 1, 1); chk_latch(6'h12, "R9 drive1 side");

    // R11: accesses that must not disturb latch or pulse
    held = 6'h12;
    np0  = npulse;
    for (int p = 0; p < 15; p++) begin
      if (p != 8) begin
        access(16'h00E0 + 16'(p), 8'h3F, 0, 1, 1);
        chk_latch(held, "R11 other port write");
      end
    end
    access(16'h00EF, 8'h24, 0, 1, 0); chk_latch(held, "R11 write without iocyc");
    access(16'h00EF, 8'h24, 1, 0, 1); chk_latch(held, "R11 read of latch port");
    access(16'h00E8, 8'h00, 1, 0, 1);
    access(16'h00E8, 8'h00, 0, 1, 0);
    access(16'h00DF, 8'h24, 0, 1, 1); chk_latch(held, "R11 outside window");
    repeat (RL) @(negedge clk);
    chk(npulse == np0, "R11 no pulse", npulse, np0);
    chk(fdc_mr_n == 1'b1, "R11 mr_n idle", fdc_mr_n, 1);

    // R12: reset in mid-pulse clears state
    access(16'h00E8, 8'h00, 0, 1, 1);
    chk(fdc_mr_n == 1'b0, "R7 pulse running", fdc_mr_n, 0);
    do_reset();
    chk(fdc_mr_n == 1'b1, "R12 pulse cut", fdc_mr_n, 1);
    chk_latch(6'd0, "R12 latch cleared");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule